// File: doc/BRIEF.md
# Eight-bit accumulator CPU core

The core is a small processor built around one 8-bit accumulator, an 8-bit instruction pointer and a 4-bit flag register. Each instruction takes two bytes: an opcode byte and then an operand byte. The core reads them from a 256-byte unified memory through a single synchronous port, which returns read data one cycle after the address is presented. Sixteen operations are provided: load, store, add, subtract, compare-and-skip, jump, flag toggle, flag-test-and-skip, no-op and halt. Most of them exist in two forms. One takes the operand byte as a literal. The other takes the operand byte as the address of the value.

The core does not reset into a fixed address. It fetches its starting instruction pointer from the top memory location. Because that location acts as a boot vector, the core never issues a write to it. After a halt instruction the core stops all memory traffic and holds its halted output high until the next reset.

Top module: `acc8_core`

## Requirements
- R1: While reset is held, the core presents address 0xFF with no write and halted low. After release, the instruction pointer is loaded with the byte at 0xFF, and the first instruction is fetched from that address.
- R2: Instruction timing. The boot vector read takes 2 cycles. An instruction in literal form (opcodes 0x0,0x1,0x3,0x5,0x7,0x9,0xB,0xD,0xE,0xF) takes 3 cycles. An instruction in memory form (0x2,0x4,0x6,0x8,0xA,0xC) takes 4 cycles. An instruction that neither jumps nor skips advances the pointer by 2.
- R3: Load (0x3 literal, 0x4 loads mem[operand]) sets the accumulator. It updates N (bit 2) = result bit 7 and Z (bit 1) = result is zero. It leaves O (bit 3) and C (bit 0) unchanged.
- R4: Add (0x5 literal, 0x6 memory) wraps modulo 256. It sets C to the carry out and O to signed overflow, and updates N and Z.
- R5: Subtract (0x7 literal, 0x8 memory) wraps modulo 256. It sets C to the borrow (accumulator below operand) and O to signed overflow, and updates N and Z.
- R6: Store 0x1 writes the accumulator to mem[operand]. Store 0x2 writes it to mem[mem[operand]].
- R7: No write ever reaches address 0xFF. A store aimed there leaves the byte unchanged.
- R8: Compare-and-skip (0x9 literal, 0xA memory) advances the pointer by 4 when the accumulator equals the value, and by 2 otherwise.
- R9: Jump 0xB loads the pointer with the operand. Jump 0xC loads it with mem[operand].
- R10: Flag toggle 0xD inverts the flag numbered by operand bits 1:0 (O=3, N=2, Z=1, C=0). Operand bits 7:2 are ignored.
- R11: Flag-test-and-skip 0xE advances the pointer by 4 when the flag numbered by operand bits 1:0 is set, and by 2 otherwise.
- R12: Halt (0x0) raises halted, which then stays high with no memory write until reset.
- R13: Opcode bits 7:4 are ignored. The operands of halt and no-op (0xF) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data (accumulator) |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the address |
| halted_o | output | 1 | Core has executed halt |

## Verification
Every result is due a fixed number of cycles after reset is released. The boot read takes two cycles, each literal-form instruction adds three and each memory-form instruction adds four, so halted must first be seen exactly that many rising edges after release. The bench counts rising edges from the release of reset and samples halted at the following falling edge. Its reference model adds up the same per-instruction costs, so a result that arrives one cycle early or one cycle late is reported. Memory effects are compared byte for byte against the reference once halted is seen, and halted is then watched for a further stretch to confirm that it holds and that no write occurs.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_N = 2;
  localparam int unsigned FL_O = 3;
  localparam int unsigned NFLAGS = 4;

  typedef enum logic [3:0] {
    K_NOP, K_END, K_STO, K_LDA, K_ADD, K_SUB, K_HOP, K_JMP, K_FTG, K_FHP
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  mem_form;
  } dec_t;

  typedef enum logic [2:0] {
    ST_BOOT_A, ST_BOOT_D, ST_FETCH_A, ST_FETCH_B, ST_EXEC, ST_MEM_D, ST_HALT
  } state_e;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [3:0] op_i,
  output dec_t       dec_o
);

  always_comb begin
    dec_o.mem_form = 1'b0;
    unique case (op_i)
      4'h0:        dec_o.kind = K_END;
      4'h1, 4'h2:  dec_o.kind = K_STO;
      4'h3, 4'h4:  dec_o.kind = K_LDA;
      4'h5, 4'h6:  dec_o.kind = K_ADD;
      4'h7, 4'h8:  dec_o.kind = K_SUB;
      4'h9, 4'hA:  dec_o.kind = K_HOP;
      4'hB, 4'hC:  dec_o.kind = K_JMP;
      4'hD:        dec_o.kind = K_FTG;
      4'hE:        dec_o.kind = K_FHP;
      default:     dec_o.kind = K_NOP;
    endcase
    // paired codes: even member reads its value from memory
    if (op_i inside {4'h2, 4'h4, 4'h6, 4'h8, 4'hA, 4'hC}) dec_o.mem_form = 1'b1;
  end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  kind_e             kind_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     v_i,
  input  logic [NFLAGS-1:0] flags_i,
  output logic [DW-1:0]     res_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic              eq_o
);

  localparam int unsigned MSB = DW - 1;

  logic [DW:0] sum, dif;

  assign sum  = {1'b0, a_i} + {1'b0, v_i};
  assign dif  = {1'b0, a_i} - {1'b0, v_i};
  assign eq_o = (a_i == v_i);

  always_comb begin
    res_o   = v_i;
    flags_o = flags_i;
    unique case (kind_i)
      K_ADD: begin
        res_o          = sum[DW-1:0];
        flags_o[FL_C]  = sum[DW];
        flags_o[FL_O]  = (a_i[MSB] == v_i[MSB]) && (res_o[MSB] != a_i[MSB]);
      end
      K_SUB: begin
        res_o          = dif[DW-1:0];
        flags_o[FL_C]  = dif[DW];
        flags_o[FL_O]  = (a_i[MSB] != v_i[MSB]) && (res_o[MSB] != a_i[MSB]);
      end
      K_FTG: flags_o[v_i[1:0]] = ~flags_i[v_i[1:0]];
      default: ;
    endcase
    if (kind_i inside {K_ADD, K_SUB, K_LDA}) begin
      flags_o[FL_N] = res_o[MSB];
      flags_o[FL_Z] = (res_o == '0);
    end
  end

endmodule

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
  import acc8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [DW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              halted_o,
  output logic [3:0]        op_o,
  input  dec_t              dec_i,
  output logic [DW-1:0]     acc_o,
  output logic [NFLAGS-1:0] flags_o,
  input  logic [DW-1:0]     alu_res_i,
  input  logic [NFLAGS-1:0] alu_flags_i,
  input  logic              alu_eq_i
);

  localparam logic [DW-1:0] BOOT_VEC = '1;

  state_e            state_q;
  logic [DW-1:0]     ip_q, acc_q, ip_nxt, ip_p2, ip_p4;
  logic [NFLAGS-1:0] flags_q;
  logic [3:0]        op_q;
  logic              fin, wr_req, acc_we, flg_we;

  assign op_o        = op_q;
  assign acc_o       = acc_q;
  assign flags_o     = flags_q;
  assign mem_wdata_o = acc_q;
  assign halted_o    = (state_q == ST_HALT);

  assign ip_p2 = ip_q + DW'(2);
  assign ip_p4 = ip_q + DW'(4);

  // instruction completes: literal forms in EXEC, memory forms in MEM_D
  assign fin    = (state_q == ST_EXEC && !dec_i.mem_form) || (state_q == ST_MEM_D);
  assign acc_we = dec_i.kind inside {K_LDA, K_ADD, K_SUB};
  assign flg_we = dec_i.kind inside {K_LDA, K_ADD, K_SUB, K_FTG};
  assign wr_req = (dec_i.kind == K_STO) &&
                  ((state_q == ST_EXEC && !dec_i.mem_form) || state_q == ST_MEM_D);
  // boot vector location is read-only
  assign mem_we_o = wr_req && (mem_rdata_i != BOOT_VEC);

  always_comb begin
    unique case (state_q)
      ST_BOOT_A, ST_BOOT_D: mem_addr_o = BOOT_VEC;
      ST_FETCH_A:           mem_addr_o = ip_q;
      ST_FETCH_B:           mem_addr_o = ip_q + DW'(1);
      ST_EXEC:              mem_addr_o = (dec_i.mem_form || dec_i.kind == K_STO) ? mem_rdata_i : ip_q;
      ST_MEM_D:             mem_addr_o = (dec_i.kind == K_STO) ? mem_rdata_i : ip_q;
      default:              mem_addr_o = ip_q;
    endcase
  end

  always_comb begin
    unique case (dec_i.kind)
      K_JMP:   ip_nxt = mem_rdata_i;
      K_HOP:   ip_nxt = alu_eq_i ? ip_p4 : ip_p2;
      K_FHP:   ip_nxt = flags_q[mem_rdata_i[1:0]] ? ip_p4 : ip_p2;
      default: ip_nxt = ip_p2;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT_A;
      ip_q    <= '0;
      acc_q   <= '0;
      flags_q <= '0;
      op_q    <= '0;
    end else begin
      unique case (state_q)
        ST_BOOT_A:  state_q <= ST_BOOT_D;
        ST_BOOT_D: begin
          ip_q    <= mem_rdata_i;
          state_q <= ST_FETCH_A;
        end
        ST_FETCH_A: state_q <= ST_FETCH_B;
        ST_FETCH_B: begin
          op_q    <= mem_rdata_i[3:0];
          state_q <= ST_EXEC;
        end
        ST_EXEC, ST_MEM_D: begin
          if (fin) begin
            if (acc_we) acc_q <= alu_res_i;
            if (flg_we) flags_q <= alu_flags_i;
            ip_q    <= ip_nxt;
            state_q <= (dec_i.kind == K_END) ? ST_HALT : ST_FETCH_A;
          end else begin
            state_q <= ST_MEM_D;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  AST_BOOT_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BOOT_D) |=> (ip_q == $past(mem_rdata_i))); // R1

  AST_PLAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && dec_i.kind inside {K_NOP, K_STO, K_LDA, K_ADD, K_SUB})
      |=> (ip_q == DW'($past(ip_q) + DW'(2)))); // R2

  AST_LOAD_KEEPS_OC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && dec_i.kind == K_LDA)
      |=> (flags_q[FL_O] == $past(flags_q[FL_O]) && flags_q[FL_C] == $past(flags_q[FL_C]))); // R3

  AST_TOGGLE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && dec_i.kind == K_FTG) |=> ($countones(flags_q ^ $past(flags_q)) == 1)); // R10

  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_we_o)); // R12

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          halted_o
);

  dec_t              dec;
  logic [3:0]        op;
  logic [DW-1:0]     acc, alu_res;
  logic [NFLAGS-1:0] flags, alu_flags;
  logic              alu_eq;

  acc8_decode u_decode (
    .op_i  (op),
    .dec_o (dec)
  );

  acc8_alu #(.DW(DW)) u_alu (
    .kind_i  (dec.kind),
    .a_i     (acc),
    .v_i     (mem_rdata_i),
    .flags_i (flags),
    .res_o   (alu_res),
    .flags_o (alu_flags),
    .eq_o    (alu_eq)
  );

  acc8_ctrl #(.DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .halted_o    (halted_o),
    .op_o        (op),
    .dec_i       (dec),
    .acc_o       (acc),
    .flags_o     (flags),
    .alu_res_i   (alu_res),
    .alu_flags_i (alu_flags),
    .alu_eq_i    (alu_eq)
  );

endmodule

// File: tb/acc8_core_tb_top.sv
module acc8_core_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] addr, wdata;
  logic [7:0] rdata = '0;
  logic       we, halted;
  logic [7:0] mem     [256];
  logic [7:0] img     [256];
  logic [7:0] ref_mem [256];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc8_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (addr),
    .mem_we_o    (we),
    .mem_wdata_o (wdata),
    .mem_rdata_i (rdata),
    .halted_o    (halted)
  );

  always @(posedge clk) begin
    if (load) mem <= img;
    else begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ref_wr(input logic [7:0] a, input logic [7:0] d);
    if (a != 8'hFF) ref_mem[a] = d;
  endtask

  // reference model built from the requirements; returns expected halt cycle
  task automatic ref_run(output int cyc);
    logic [7:0] ip, acc, arg, v, r, nip;
    logic [3:0] op, f;
    logic [8:0] s;
    bit done, memf;
    ip = ref_mem[255]; acc = '0; f = '0; cyc = 2; done = 0;
    for (int step = 0; step < 4000 && !done; step++) begin
      op   = ref_mem[ip][3:0];
      arg  = ref_mem[8'(ip + 8'd1)];
      memf = (op >= 4'h1) && (op <= 4'hC) && !op[0];
      v    = memf ? ref_mem[arg] : arg;
      cyc += memf ? 4 : 3;
      nip  = 8'(ip + 8'd2);
      case (op)
        4'h0: done = 1;
        4'h1: ref_wr(arg, acc);
        4'h2: ref_wr(v, acc);
        4'h3, 4'h4: begin acc = v; f[2] = acc[7]; f[1] = (acc == 0); end
        4'h5, 4'h6: begin
          s = {1'b0, acc} + {1'b0, v}; r = s[7:0];
          f[3] = (acc[7] == v[7]) && (r[7] != acc[7]); f[0] = s[8];
          acc = r; f[2] = acc[7]; f[1] = (acc == 0);
        end
        4'h7, 4'h8: begin
          s = {1'b0, acc} - {1'b0, v}; r = s[7:0];
          f[3] = (acc[7] != v[7]) && (r[7] != acc[7]); f[0] = s[8];
          acc = r; f[2] = acc[7]; f[1] = (acc == 0);
        end
        4'h9, 4'hA: if (acc == v) nip = 8'(ip + 8'd4);
        4'hB, 4'hC: nip = v;
        4'hD: f[arg[1:0]] = ~f[arg[1:0]];
        4'hE: if (f[arg[1:0]]) nip = 8'(ip + 8'd4);
        default: ;
      endcase
      ip = nip;
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    img[255] = 8'h20;
  endtask

  task automatic put(input int at, input logic [7:0] op, input logic [7:0] arg);
    img[at] = op;
    img[at+1] = arg;
  endtask

  task automatic run_prog(input string req, input bit watch_halt);
    int exp_cyc, cnt, bad;
    rst_n = 1'b0;
    load  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    ref_mem = img;
    ref_run(exp_cyc);
    rst_n = 1'b1;
    cnt = 0;
    while (!halted && cnt < exp_cyc + 100) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    chk(halted == 1'b1, "R12", {req, " halted reached"}, int'(halted), 1);
    chk(cnt == exp_cyc, "R2", {req, " cycles to halt"}, cnt, exp_cyc);
    bad = -1;
    for (int i = 255; i >= 0; i--) if (mem[i] !== ref_mem[i]) bad = i;
    chk(bad < 0, req, "memory image (first bad addr / its value)",
        bad < 0 ? 0 : int'(mem[bad]), bad < 0 ? 0 : int'(ref_mem[bad]));
    if (watch_halt) begin
      bad = 0;
      for (int k = 0; k < 20; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (!halted || we) bad++;
      end
      chk(bad == 0, "R12", "halted held without writes", bad, 0);
    end
  endtask

  task automatic gen_random();
    int n;
    logic [3:0] op;
    logic [7:0] arg, opb;
    clear_img();
    for (int i = 0; i < 32; i++) img[i] = 8'($urandom);
    for (int i = 'hA0; i < 'hC0; i++) img[i] = 8'(8'hC0 + ($urandom % 64));
    for (int i = 'hC0; i < 'hFF; i++) img[i] = 8'($urandom);
    n = 8 + ($urandom % 32);
    for (int k = 0; k < n; k++) begin
      op = 4'($urandom % 16);
      if (op == 4'h0 || op == 4'hB || op == 4'hC) op = 4'h3;
      case (op)
        4'h1:    arg = 8'(8'hC0 + ($urandom % 64)); // may hit 0xFF (R7)
        4'h2:    arg = 8'(8'hA0 + ($urandom % 32));
        default: arg = 8'($urandom);
      endcase
      opb = {(($urandom % 4) == 0) ? 4'($urandom) : 4'h0, op}; // R13 upper nibble
      put(32 + 2*k, opb, arg);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_img();
    load = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    // R1 reset state
    chk(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
    chk(we == 1'b0, "R1", "write in reset", int'(we), 0);
    chk(addr == 8'hFF, "R1", "address in reset", int'(addr), 255);

    // R1 boot vector
    clear_img(); img[255] = 8'h50;
    put('h20, 8'h03, 8'h99); put('h22, 8'h01, 8'hC1);
    put('h50, 8'h03, 8'h5A); put('h52, 8'h01, 8'hC0); put('h54, 8'h00, 8'h00);
    run_prog("R1 boot", 0);

    // R3 load forms, N/Z, O/C preserved
    clear_img(); img['hB0] = 8'h80;
    put('h20, 8'h03, 8'h7F); put('h22, 8'h05, 8'h01); put('h24, 8'h04, 8'hB0);
    put('h26, 8'h01, 8'hC0); put('h28, 8'h0E, 8'h03); put('h2A, 8'h01, 8'hC1);
    put('h2C, 8'h0E, 8'h02); put('h2E, 8'h01, 8'hC2); put('h30, 8'h03, 8'h00);
    put('h32, 8'h0E, 8'h01); put('h34, 8'h01, 8'hC3); put('h36, 8'h00, 8'h00);
    run_prog("R3 load", 0);

    // R4 add carry and overflow
    clear_img(); img['hB0] = 8'h01;
    put('h20, 8'h03, 8'hFF); put('h22, 8'h06, 8'hB0); put('h24, 8'h0E, 8'h00);
    put('h26, 8'h01, 8'hC0); put('h28, 8'h0E, 8'h01); put('h2A, 8'h01, 8'hC1);
    put('h2C, 8'h03, 8'h40); put('h2E, 8'h05, 8'h40); put('h30, 8'h0E, 8'h03);
    put('h32, 8'h01, 8'hC2); put('h34, 8'h00, 8'h00);
    run_prog("R4 add", 0);

    // R5 subtract borrow and overflow
    clear_img(); img['hB0] = 8'h01;
    put('h20, 8'h03, 8'h10); put('h22, 8'h07, 8'h20); put('h24, 8'h0E, 8'h00);
    put('h26, 8'h01, 8'hC0); put('h28, 8'h03, 8'h80); put('h2A, 8'h08, 8'hB0);
    put('h2C, 8'h0E, 8'h03); put('h2E, 8'h01, 8'hC1); put('h30, 8'h00, 8'h00);
    run_prog("R5 sub", 0);

    // R6 / R7 stores, both forms, incl. 0xFF target
    clear_img(); img['hA0] = 8'hD5; img['hA1] = 8'hFF;
    put('h20, 8'h03, 8'hAA); put('h22, 8'h01, 8'hC4); put('h24, 8'h02, 8'hA0);
    put('h26, 8'h01, 8'hFF); put('h28, 8'h02, 8'hA1); put('h2A, 8'h00, 8'h00);
    run_prog("R6 R7 store", 0);

    // R8 compare-and-skip equal / unequal
    clear_img(); img['hB0] = 8'h33;
    put('h20, 8'h03, 8'h33); put('h22, 8'h09, 8'h33); put('h24, 8'h01, 8'hC0);
    put('h26, 8'h0A, 8'hB0); put('h28, 8'h01, 8'hC1); put('h2A, 8'h09, 8'h34);
    put('h2C, 8'h01, 8'hC2); put('h2E, 8'h00, 8'h00);
    run_prog("R8 hop", 0);

    // R9 jumps
    clear_img(); img['hA0] = 8'h60;
    put('h20, 8'h0B, 8'h40); put('h22, 8'h01, 8'hC0);
    put('h40, 8'h03, 8'h11); put('h42, 8'h01, 8'hC1); put('h44, 8'h0C, 8'hA0);
    put('h46, 8'h01, 8'hC2); put('h60, 8'h01, 8'hC3); put('h62, 8'h00, 8'h00);
    run_prog("R9 jump", 0);

    // R10 / R11 toggle and flag skip, operand upper bits ignored
    clear_img();
    put('h20, 8'h03, 8'h05); put('h22, 8'h0D, 8'hFC); put('h24, 8'h0E, 8'h04);
    put('h26, 8'h01, 8'hC0); put('h28, 8'h0D, 8'h03); put('h2A, 8'h0E, 8'h03);
    put('h2C, 8'h01, 8'hC1); put('h2E, 8'h0E, 8'h02); put('h30, 8'h01, 8'hC2);
    put('h32, 8'h00, 8'h00);
    run_prog("R10 R11 flags", 0);

    // R13 upper opcode nibble and NOP operand; R12 halt holds
    clear_img();
    put('h20, 8'hF3, 8'h21); put('h22, 8'h0F, 8'hC5); put('h24, 8'h91, 8'hC0);
    put('h26, 8'h00, 8'hC1);
    run_prog("R13 ignore", 1);

    for (int t = 0; t < 60; t++) begin
      gen_random();
      run_prog("R6 random", t < 2);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule